// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Host Wakeup

This block decides who may touch a single non-volatile memory that is reachable from two sides: a wired two-wire serial slave used by a host processor, and a radio command engine. It keeps one of three operating modes at all times. In idle the radio side may receive commands. In wired control the host owns the memory. In internal control the block itself is busy with power-up initialisation, a memory write, a reply transmission or the execution of a radio command, and both sides are shut out.

The serial slave reports address-match, address-miss (a new START with a foreign address), STOP and "a write was commanded" as single-cycle events. The radio engine reports command-received (with flags for whether the command writes memory or needs a reply) and reply-finished. The wired side takes priority over the radio side whenever the block is idle, but it cannot break into an internal operation. Durations of initialisation, memory write and the reply timeout are parameters in clock cycles, and the memory's own busy flag can stretch any internal operation.

A wakeup option lets a sleeping host notice radio activity. When it is enabled and the DC supply is absent, the block pulls the serial clock line low for as long as a radio-initiated memory write lasts.

Top module: `nvm_port_arbiter`

## Requirements
- R1: While reset is high and for exactly INIT_CYCLES clock cycles after it falls, internal_busy is 1 and both grants are 0; afterwards the block is idle.
- R2: At most one of i2c_grant, rf_grant and internal_busy is 1 at any time; in idle an address-match event moves the block to wired control (i2c_grant = 1 after the next edge) regardless of the DC supply and radio enable settings.
- R3: While internal_busy is 1, address-match events and radio command events are ignored: the block never goes straight from internal control to wired control.
- R4: In wired control, radio command events are ignored and the block stays in wired control for any number of cycles until STOP or address-miss.
- R5: On STOP or address-miss in wired control, the block enters internal control for WRITE_CYCLES cycles if a write-command event was seen during that wired session (including in the same cycle), and otherwise returns to idle.
- R6: If address-match and command-received arrive in the same idle cycle, wired control is entered and the radio command is dropped.
- R7: An accepted radio command enters internal control: for WRITE_CYCLES cycles if its write flag is 1; else, if its reply flag is 1, until reply-finished or REPLY_CYCLES cycles, whichever is first; else for one cycle.
- R8: Internal control does not end in any cycle where mem_busy is 1.
- R9: When dc_present is 1 and cfg_dc_rf_en is 0, rf_grant is 0 and radio command events in idle are ignored; with cfg_dc_rf_en at 1 the radio side is granted in idle.
- R10: scl_pull_low is 1 exactly while internal control is executing a radio-initiated write, cfg_wake_en is 1 and dc_present is 0; host-initiated writes never pull the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i2c_addr_match | input | 1 | Pulse: START/repeated START with this device's address |
| i2c_addr_miss | input | 1 | Pulse: new START carrying a foreign address |
| i2c_stop | input | 1 | Pulse: STOP seen on the serial bus |
| i2c_wr_cmd | input | 1 | Pulse: a valid memory write was commanded in this session |
| rf_cmd_done | input | 1 | Pulse: a radio command has been fully received |
| rf_cmd_write | input | 1 | Qualifier of rf_cmd_done: command writes memory |
| rf_cmd_reply | input | 1 | Qualifier of rf_cmd_done: command needs a reply |
| rf_reply_done | input | 1 | Pulse: reply transmission finished |
| mem_busy | input | 1 | Memory still busy; holds internal control |
| dc_present | input | 1 | DC supply is present |
| cfg_dc_rf_en | input | 1 | Allow radio access while DC supply is present |
| cfg_wake_en | input | 1 | Enable host wakeup on radio writes |
| i2c_grant | output | 1 | Wired side owns the memory |
| rf_grant | output | 1 | Radio side may receive commands |
| internal_busy | output | 1 | Internal operation in progress |
| scl_pull_low | output | 1 | Drive the serial clock pin low |

## Verification
A wrong mode register shows up one edge after the offending event as a grant that is high when it should be low, or as two of the three mode outputs high together, so the mode outputs are compared after every stimulus cycle. A wrong timer load or a missed mem_busy hold shows only at the end of an internal operation, so each duration is checked on its last busy cycle and on the first idle cycle after it. A wrong write-origin tag shows on scl_pull_low from the first cycle of the write.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_WIRED    = 2'd1,
        MODE_INTERNAL = 2'd2
    } arb_mode_e;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_INIT        = 3'd1,
        CAUSE_HOST_WRITE  = 3'd2,
        CAUSE_RADIO_WRITE = 3'd3,
        CAUSE_REPLY       = 3'd4,
        CAUSE_EXEC        = 3'd5
    } int_cause_e;

    typedef struct packed {
        logic addr_match;
        logic addr_miss;
        logic stop;
        logic wr_cmd;
    } wired_ev_t;

    typedef struct packed {
        logic cmd_done;
        logic cmd_write;
        logic cmd_reply;
        logic reply_done;
    } radio_ev_t;

    typedef struct packed {
        arb_mode_e  mode;
        int_cause_e cause;
        logic       wr_pending;
    } arb_state_t;

    // Radio path is open unless DC is present and radio use under DC is disallowed
    function automatic logic radio_path_open(input logic dc, input logic dc_rf_en);
        return !(dc && !dc_rf_en);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/arb_timer.sv
module arb_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/arb_state.sv
module arb_state
    import arb_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WRITE_LOAD = 7,
    parameter int REPLY_LOAD = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  wired_ev_t        wev,
    input  radio_ev_t        rev,
    input  logic             rf_open,
    input  logic             tmr_zero,
    input  logic             mem_busy,
    output arb_state_t       st,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] WR_V  = CNT_W'(WRITE_LOAD);
    localparam logic [CNT_W-1:0] RPL_V = CNT_W'(REPLY_LOAD);

    arb_state_t nx;

    always_comb begin
        nx       = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st.mode)
            MODE_IDLE: begin
                if (wev.addr_match) begin
                    // wired side wins any same-cycle contest
                    nx.mode       = MODE_WIRED;
                    nx.wr_pending = 1'b0;
                end else if (rf_open && rev.cmd_done) begin
                    nx.mode  = MODE_INTERNAL;
                    tmr_load = 1'b1;
                    if (rev.cmd_write) begin
                        nx.cause = CAUSE_RADIO_WRITE;
                        tmr_val  = WR_V;
                    end else if (rev.cmd_reply) begin
                        nx.cause = CAUSE_REPLY;
                        tmr_val  = RPL_V;
                    end else begin
                        nx.cause = CAUSE_EXEC;
                        tmr_val  = '0;
                    end
                end
            end
            MODE_WIRED: begin
                if (wev.wr_cmd) nx.wr_pending = 1'b1;
                if (wev.stop || wev.addr_miss) begin
                    nx.wr_pending = 1'b0;
                    if (st.wr_pending || wev.wr_cmd) begin
                        nx.mode  = MODE_INTERNAL;
                        nx.cause = CAUSE_HOST_WRITE;
                        tmr_load = 1'b1;
                        tmr_val  = WR_V;
                    end else begin
                        nx.mode = MODE_IDLE;
                    end
                end
            end
            MODE_INTERNAL: begin
                if (!mem_busy &&
                    (tmr_zero || (st.cause == CAUSE_REPLY && rev.reply_done))) begin
                    nx.mode  = MODE_IDLE;
                    nx.cause = CAUSE_NONE;
                end
            end
            default: begin
                nx.mode       = MODE_IDLE;
                nx.cause      = CAUSE_NONE;
                nx.wr_pending = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode       <= MODE_INTERNAL;
            st.cause      <= CAUSE_INIT;
            st.wr_pending <= 1'b0;
        end else begin
            st <= nx;
        end
    end
endmodule

// File: rtl/arb_gate.sv
module arb_gate
    import arb_pkg::*;
#(
    parameter bit WAKE_HW = 1'b1
) (
    input  arb_mode_e  mode,
    input  int_cause_e cause,
    input  logic       dc_present,
    input  logic       cfg_dc_rf_en,
    input  logic       cfg_wake_en,
    output logic       rf_open,
    output logic       i2c_grant,
    output logic       rf_grant,
    output logic       internal_busy,
    output logic       scl_pull_low
);
    assign rf_open       = radio_path_open(dc_present, cfg_dc_rf_en);
    assign i2c_grant     = (mode == MODE_WIRED);
    assign internal_busy = (mode == MODE_INTERNAL);
    assign rf_grant      = (mode == MODE_IDLE) && rf_open;

    generate
        if (WAKE_HW) begin : g_wake
            assign scl_pull_low = internal_busy && (cause == CAUSE_RADIO_WRITE) &&
                                  cfg_wake_en && !dc_present;
        end else begin : g_nowake
            assign scl_pull_low = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/nvm_port_arbiter.sv
module nvm_port_arbiter
    import arb_pkg::*;
#(
    parameter int INIT_CYCLES  = 200_000,
    parameter int WRITE_CYCLES = 500_000,
    parameter int REPLY_CYCLES = 2_000_000,
    parameter bit WAKE_HW      = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic i2c_addr_match,
    input  logic i2c_addr_miss,
    input  logic i2c_stop,
    input  logic i2c_wr_cmd,
    input  logic rf_cmd_done,
    input  logic rf_cmd_write,
    input  logic rf_cmd_reply,
    input  logic rf_reply_done,
    input  logic mem_busy,
    input  logic dc_present,
    input  logic cfg_dc_rf_en,
    input  logic cfg_wake_en,
    output logic i2c_grant,
    output logic rf_grant,
    output logic internal_busy,
    output logic scl_pull_low
);
    localparam int unsigned MAX_CYC = max3(INIT_CYCLES, WRITE_CYCLES, REPLY_CYCLES);
    localparam int          CNT_W   = $clog2(MAX_CYC) + 1;

    wired_ev_t        wev;
    radio_ev_t        rev;
    arb_state_t       st;
    logic             rf_open;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    assign wev = '{addr_match: i2c_addr_match, addr_miss: i2c_addr_miss,
                   stop: i2c_stop, wr_cmd: i2c_wr_cmd};
    assign rev = '{cmd_done: rf_cmd_done, cmd_write: rf_cmd_write,
                   cmd_reply: rf_cmd_reply, reply_done: rf_reply_done};

    arb_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(INIT_CYCLES - 1)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .run     (st.mode == MODE_INTERNAL),
        .zero    (tmr_zero)
    );

    arb_state #(
        .CNT_W     (CNT_W),
        .WRITE_LOAD(WRITE_CYCLES - 1),
        .REPLY_LOAD(REPLY_CYCLES - 1)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .wev     (wev),
        .rev     (rev),
        .rf_open (rf_open),
        .tmr_zero(tmr_zero),
        .mem_busy(mem_busy),
        .st      (st),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val)
    );

    arb_gate #(
        .WAKE_HW(WAKE_HW)
    ) u_gate (
        .mode         (st.mode),
        .cause        (st.cause),
        .dc_present   (dc_present),
        .cfg_dc_rf_en (cfg_dc_rf_en),
        .cfg_wake_en  (cfg_wake_en),
        .rf_open      (rf_open),
        .i2c_grant    (i2c_grant),
        .rf_grant     (rf_grant),
        .internal_busy(internal_busy),
        .scl_pull_low (scl_pull_low)
    );
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
    input logic clk,
    input logic rst,
    input logic i2c_addr_match,
    input logic i2c_addr_miss,
    input logic i2c_stop,
    input logic mem_busy,
    input logic dc_present,
    input logic cfg_dc_rf_en,
    input logic cfg_wake_en,
    input logic i2c_grant,
    input logic rf_grant,
    input logic internal_busy,
    input logic scl_pull_low
);
    // R2
    grant_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({i2c_grant, rf_grant, internal_busy}));

    // R2
    idle_match_enters_wired_chk: assert property (@(posedge clk) disable iff (rst)
        (!internal_busy && !i2c_grant && i2c_addr_match) |=> i2c_grant);

    // R3
    internal_never_to_wired_chk: assert property (@(posedge clk) disable iff (rst)
        internal_busy |=> !i2c_grant);

    // R4
    wired_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (i2c_grant && !i2c_stop && !i2c_addr_miss) |=> i2c_grant);

    // R8
    busy_holds_internal_chk: assert property (@(posedge clk) disable iff (rst)
        (internal_busy && mem_busy) |=> internal_busy);

    // R9
    dc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_present && !cfg_dc_rf_en) |-> !rf_grant);

    // R10
    wake_pull_chk: assert property (@(posedge clk) disable iff (rst)
        scl_pull_low |-> (internal_busy && cfg_wake_en && !dc_present));
endmodule

bind nvm_port_arbiter arb_checker u_arb_checker (
    .clk           (clk),
    .rst           (rst),
    .i2c_addr_match(i2c_addr_match),
    .i2c_addr_miss (i2c_addr_miss),
    .i2c_stop      (i2c_stop),
    .mem_busy      (mem_busy),
    .dc_present    (dc_present),
    .cfg_dc_rf_en  (cfg_dc_rf_en),
    .cfg_wake_en   (cfg_wake_en),
    .i2c_grant     (i2c_grant),
    .rf_grant      (rf_grant),
    .internal_busy (internal_busy),
    .scl_pull_low  (scl_pull_low)
);

// File: tb/nvm_port_arbiter_bench.sv
module nvm_port_arbiter_bench;
    localparam int INIT_C  = 4;
    localparam int WRITE_C = 8;
    localparam int REPLY_C = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i2c_addr_match = 0, i2c_addr_miss = 0, i2c_stop = 0, i2c_wr_cmd = 0;
    logic rf_cmd_done = 0, rf_cmd_write = 0, rf_cmd_reply = 0, rf_reply_done = 0;
    logic mem_busy = 0, dc_present = 0, cfg_dc_rf_en = 0, cfg_wake_en = 0;
    logic i2c_grant, rf_grant, internal_busy, scl_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nvm_port_arbiter #(
        .INIT_CYCLES (INIT_C),
        .WRITE_CYCLES(WRITE_C),
        .REPLY_CYCLES(REPLY_C)
    ) u_nvm_port_arbiter (
        .clk(clk), .rst(rst),
        .i2c_addr_match(i2c_addr_match), .i2c_addr_miss(i2c_addr_miss),
        .i2c_stop(i2c_stop), .i2c_wr_cmd(i2c_wr_cmd),
        .rf_cmd_done(rf_cmd_done), .rf_cmd_write(rf_cmd_write),
        .rf_cmd_reply(rf_cmd_reply), .rf_reply_done(rf_reply_done),
        .mem_busy(mem_busy), .dc_present(dc_present),
        .cfg_dc_rf_en(cfg_dc_rf_en), .cfg_wake_en(cfg_wake_en),
        .i2c_grant(i2c_grant), .rf_grant(rf_grant),
        .internal_busy(internal_busy), .scl_pull_low(scl_pull_low)
    );

    // Row: [15:12] match miss stop wrcmd | [11:8] rfdone rfwrite rfreply replydone
    //      [7:4] busy dc dcen wake | [3:0] exp i2c_grant rf_grant internal scl
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        16'b0000_0000_0001_0100,  // idle
        16'b1000_1000_0001_1000,  // match + radio cmd same cycle
        16'b0000_1000_0001_1000,  // radio cmd in wired
        16'b0000_0000_0001_1000,  // bus held
        16'b0100_0000_0001_0100,  // miss, no write
        16'b1000_0000_0001_1000,  // match
        16'b0010_0000_0001_0100,  // stop, no write
        16'b0000_1000_0001_0010,  // plain radio cmd -> one cycle internal
        16'b1000_0000_0001_0100,  // match during internal ignored
        16'b0000_0000_0101_0000,  // DC present, radio disabled
        16'b0000_1000_0101_0000,  // radio cmd ignored under DC
        16'b0000_0000_0111_0100,  // DC present, radio allowed
        16'b0000_1010_0001_0010,  // reply command
        16'b0000_0001_0001_0100,  // reply done
        16'b1000_0000_0101_1000,  // wired works under DC
        16'b0010_0000_0101_0000   // stop -> idle, radio gated
    };

    function automatic string row_tag(input int i);
        case (i)
            1:             return "R6";
            2, 3:          return "R4";
            4, 5, 6:       return "R5";
            7, 12, 13:     return "R7";
            8:             return "R3";
            9, 10, 11, 15: return "R9";
            default:       return "R2";
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ei, input logic er,
                         input logic en, input logic es);
        checks++;
        if ({i2c_grant, rf_grant, internal_busy, scl_pull_low} !== {ei, er, en, es}) begin
            fails++;
            $display("FAIL %s: got grant/rf/int/scl=%b%b%b%b expected %b%b%b%b", tag,
                     i2c_grant, rf_grant, internal_busy, scl_pull_low, ei, er, en, es);
        end
    endtask

    task automatic clear_pulses();
        i2c_addr_match = 0; i2c_addr_miss = 0; i2c_stop = 0; i2c_wr_cmd = 0;
        rf_cmd_done = 0; rf_cmd_write = 0; rf_cmd_reply = 0; rf_reply_done = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset and init window
        repeat (3) tick();
        check("R1", 0, 0, 1, 0);
        rst = 0;
        tick();
        check("R1", 0, 0, 1, 0);
        repeat (INIT_C - 2) tick();
        check("R1", 0, 0, 1, 0);
        tick();
        check("R1", 0, 1, 0, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            {i2c_addr_match, i2c_addr_miss, i2c_stop, i2c_wr_cmd} = VEC[i][15:12];
            {rf_cmd_done, rf_cmd_write, rf_cmd_reply, rf_reply_done} = VEC[i][11:8];
            {mem_busy, dc_present, cfg_dc_rf_en, cfg_wake_en} = VEC[i][7:4];
            tick();
            check(row_tag(i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        clear_pulses();
        mem_busy = 0; dc_present = 0; cfg_dc_rf_en = 0; cfg_wake_en = 1;
        tick();
        check("R2", 0, 1, 0, 0);

        // R10 radio write pulls the clock line for the whole write
        rf_cmd_done = 1; rf_cmd_write = 1;
        tick(); clear_pulses();
        check("R10", 0, 0, 1, 1);
        repeat (WRITE_C - 1) tick();
        check("R7", 0, 0, 1, 1);
        tick();
        check("R7", 0, 1, 0, 0);

        // R5 host write via STOP, no wake pull, R3 match ignored
        i2c_addr_match = 1; tick(); clear_pulses();
        i2c_wr_cmd = 1; tick(); clear_pulses();
        i2c_stop = 1; tick(); clear_pulses();
        check("R5", 0, 0, 1, 0);
        i2c_addr_match = 1; tick(); clear_pulses();
        check("R3", 0, 0, 1, 0);
        repeat (WRITE_C - 2) tick();
        check("R5", 0, 0, 1, 0);
        tick();
        check("R5", 0, 1, 0, 0);

        // R5 pending write closed by address-miss
        i2c_addr_match = 1; tick(); clear_pulses();
        i2c_wr_cmd = 1; tick(); clear_pulses();
        i2c_addr_miss = 1; tick(); clear_pulses();
        check("R5", 0, 0, 1, 0);
        repeat (WRITE_C) tick();
        check("R5", 0, 1, 0, 0);

        // R8 memory busy stretches internal control
        mem_busy = 1; cfg_wake_en = 0;
        rf_cmd_done = 1; rf_cmd_write = 1; tick(); clear_pulses();
        check("R10", 0, 0, 1, 0);
        repeat (WRITE_C + 2) tick();
        check("R8", 0, 0, 1, 0);
        mem_busy = 0; tick();
        check("R8", 0, 1, 0, 0);

        // R7 reply timeout
        rf_cmd_done = 1; rf_cmd_reply = 1; tick(); clear_pulses();
        repeat (REPLY_C - 1) tick();
        check("R7", 0, 0, 1, 0);
        tick();
        check("R7", 0, 1, 0, 0);

        // R10 no pull while DC present
        dc_present = 1; cfg_dc_rf_en = 1; cfg_wake_en = 1;
        rf_cmd_done = 1; rf_cmd_write = 1; tick(); clear_pulses();
        check("R10", 0, 0, 1, 0);
        repeat (WRITE_C) tick();
        check("R10", 0, 1, 0, 0);

        finish_run();
    end
endmodule